// File: doc/BRIEF.md
# Reloading Modulus Down-Counter Timer

This block is a small programmable interval timer. A counter steps down by one each time a selected time base ticks. The time base is either stopped or the system clock divided by a power of two taken from a free-running prescaler. When a tick takes the counter to zero, an underflow flag is raised. On the next tick the counter is refilled from a modulus register, so the flag repeats with a fixed period. The flag can drive a level interrupt request.

Software sees two byte-wide locations behind a one-bit address and a write strobe. One holds the modulus value. The other is a control byte that holds the following:
- the interrupt enable
- the underflow flag, which is cleared by writing a one to it
- a self-clearing preset command that copies the modulus into the counter at once
- the rate selection

Top module: `modulus_down_timer`

## Requirements
- R1: A write with `addr`=0 stores `wdata` in the modulus register, and a read with `addr`=0 returns it on `rdata`.
- R2: Each tick decrements the counter by one. A tick that finds the counter at zero reloads it from the modulus register, so with modulus D the flag is raised every (D+1) ticks.
- R3: The underflow flag is control bit 6. It is set on the clock edge where a tick brings the counter to zero, and a tick at zero with a modulus of zero counts as reaching zero.
- R4: Writing the control byte with bit 6 at 1 clears the flag. Writing it with bit 6 at 0 leaves the flag unchanged. A set in the same cycle wins over the clear.
- R5: `irq` is a combinational level equal to the flag ANDed with the interrupt enable, which is control bit 7.
- R6: Control bits 5, 4 and 3 always read as 0.
- R7: Writing the control byte with bit 3 at 1 loads the modulus value into the counter. With modulus D and a divide ratio of 1, the flag is then raised D ticks later.
- R8: After reset the control byte reads 0x00, `irq` is low and the counter is not clocked.
- R9: Control bits 2:0 select the rate. Code 0 holds the counter. Code k from 1 to 7 gives one tick every 2^(k-1) clock cycles from a free-running prescaler.
- R10: A preset in the same cycle as a tick takes priority: the counter takes the modulus value and no flag is raised from that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register select: 0 modulus, 1 control |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt request level |

## Verification
The flag period is measured for every running rate code against several small modulus values and one full-range value. A wrong divide ratio, an off-by-one reload and a wrong tap all show up as a distinct interval, (D+1)·2^(k-1) cycles. Preset is tried once with the timer stopped and once while ticks arrive every cycle. Only the second run can tell whether the preset beats a concurrent decrement. The flag is driven into a held state with the interrupt masked, so that the write-zero, write-one and enable gating cases can each be seen separately at `rdata` and `irq`.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
    localparam int BUS_W  = 8;
    localparam int SEL_W  = 3;
    // control byte bit positions decoded by the register file
    localparam int B_IEN  = 7;
    localparam int B_FLAG = 6;
    localparam int B_PRE  = 3;

    typedef struct packed {
        logic [BUS_W-1:0] modulus;
        logic             ien;
        logic             flag;
        logic [SEL_W-1:0] sel;
    } mdt_regs_t;
endpackage

// File: rtl/mdt_prescaler.sv
module mdt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NUM_SEL = 1 << SEL_W;
    localparam int PRE_W   = NUM_SEL - 2;

    logic [PRE_W-1:0]   pre_d, pre_q;
    logic [NUM_SEL-1:0] tap;

    always_comb begin
        pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // code 0 stops, code 1 every cycle, code k when the low k-1 bits are all ones
    for (genvar k = 0; k < NUM_SEL; k++) begin : g_tap
        if (k == 0) begin : g_stop
            assign tap[k] = 1'b0;
        end else if (k == 1) begin : g_full
            assign tap[k] = 1'b1;
        end else begin : g_div
            assign tap[k] = &pre_q[k-2:0];
        end
    end

    assign tick = tap[sel];
endmodule

// File: rtl/mdt_counter.sv
module mdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             preset,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (preset) begin
            cnt_d = reload;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_d = reload;
                hit   = (reload == '0);
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
                hit   = (cnt_q == CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/mdt_regs.sv
module mdt_regs
    import mdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    input  logic             hit,
    output logic [BUS_W-1:0] modulus,
    output logic [SEL_W-1:0] sel,
    output logic             ien,
    output logic             flag,
    output logic             preset,
    output logic [BUS_W-1:0] rdata
);
    mdt_regs_t r_d, r_q;
    logic      ctrl_wr, mod_wr;

    assign ctrl_wr = wr_en & addr;
    assign mod_wr  = wr_en & ~addr;

    always_comb begin
        r_d = r_q;
        if (mod_wr) r_d.modulus = wdata;
        if (ctrl_wr) begin
            r_d.ien = wdata[B_IEN];
            r_d.sel = wdata[SEL_W-1:0];
            if (wdata[B_FLAG]) r_d.flag = 1'b0;
        end
        if (hit) r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (addr) begin
            rdata[B_IEN]       = r_q.ien;
            rdata[B_FLAG]      = r_q.flag;
            rdata[SEL_W-1:0]   = r_q.sel;
        end else begin
            rdata = r_q.modulus;
        end
    end

    assign preset  = ctrl_wr & wdata[B_PRE];
    assign modulus = r_q.modulus;
    assign sel     = r_q.sel;
    assign ien     = r_q.ien;
    assign flag    = r_q.flag;
endmodule

// File: rtl/modulus_down_timer.sv
module modulus_down_timer
    import mdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq
);
    logic [BUS_W-1:0] modulus;
    logic [BUS_W-1:0] count;
    logic [SEL_W-1:0] sel;
    logic             ien, flag, preset, tick, hit;

    mdt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .hit(hit), .modulus(modulus), .sel(sel), .ien(ien), .flag(flag),
        .preset(preset), .rdata(rdata)
    );

    mdt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(sel), .tick(tick)
    );

    mdt_counter #(.CNT_W(BUS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .preset(preset),
        .reload(modulus), .count(count), .hit(hit)
    );

    assign irq = flag & ien;
endmodule

// File: rtl/modulus_down_timer_chk.sv
module modulus_down_timer_chk
    import mdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             addr,
    input logic             wr_en,
    input logic [BUS_W-1:0] wdata,
    input logic [BUS_W-1:0] rdata,
    input logic             irq,
    input logic             tick,
    input logic             hit,
    input logic             preset,
    input logic             flag,
    input logic             ien,
    input logic [SEL_W-1:0] sel,
    input logic [BUS_W-1:0] count,
    input logic [BUS_W-1:0] modulus
);
    // R3
    flag_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick));

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && wdata[B_FLAG] && !hit) |=> !flag);

    // R4
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && addr && wdata[B_FLAG])) |=> flag);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

    // R2
    reload_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !preset && count == '0) |=> count == $past(modulus));

    // R10
    preset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> count == $past(modulus));

    // R9
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && !preset) |=> count == $past(count));

    // R6
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr |-> rdata[5:3] == 3'b000);
endmodule

bind modulus_down_timer modulus_down_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq), .tick(tick), .hit(hit), .preset(preset),
    .flag(flag), .ien(ien), .sel(sel), .count(count), .modulus(modulus)
);

// File: tb/modulus_down_timer_tb.sv
`timescale 1ns/1ps
module modulus_down_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    modulus_down_timer u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; the write is taken at the next posedge
    task automatic wr(input logic a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_irq(output int c);
        c = 0;
        while (!irq && c < 40000) begin
            @(negedge clk);
            c++;
        end
    endtask

    logic [7:0] v;
    int c;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        rd(1'b1, v);
        check("R8 ctrl after reset", v, 0);
        check("R8 irq after reset", irq, 0);

        // R1 modulus register exhaustive write/read
        for (int d = 0; d < 256; d++) begin
            wr(1'b0, 8'(d));
            rd(1'b0, v);
            check("R1 modulus readback", v, d);
        end

        // R6 unimplemented and preset bits read 0
        wr(1'b1, 8'h3F);
        rd(1'b1, v);
        check("R6 ctrl readback of 0x3F", v, 8'h07);
        wr(1'b1, 8'h40);

        // R9 stopped timer never flags
        wr(1'b0, 8'd3);
        wr(1'b1, 8'h48);
        repeat (300) @(negedge clk);
        rd(1'b1, v);
        check("R9 stopped, no flag", v, 8'h00);

        // R7 preset from stopped state, divide 1: flag after D ticks
        wr(1'b0, 8'd9);
        wr(1'b1, 8'h88);
        wr(1'b1, 8'h81);
        wait_irq(c);
        check("R7 preset to flag delay", c, 9);
        wr(1'b1, 8'h40);

        // R10 preset while ticking every cycle
        wr(1'b1, 8'h81);
        repeat (37) @(negedge clk);
        wr(1'b0, 8'd100);
        wr(1'b1, 8'hC9);
        wait_irq(c);
        check("R10 preset beats tick", c, 100);
        wr(1'b1, 8'h40);

        // R4 / R5 flag held with interrupt masked
        wr(1'b0, 8'd2);
        wr(1'b1, 8'h09);
        repeat (10) @(negedge clk);
        wr(1'b1, 8'h00);
        rd(1'b1, v);
        check("R4 write 0 keeps flag", v, 8'h40);
        check("R5 irq masked", irq, 0);
        wr(1'b1, 8'h80);
        check("R5 irq enabled", irq, 1);
        wr(1'b1, 8'hC0);
        rd(1'b1, v);
        check("R4 write 1 clears flag", v, 8'h80);
        check("R5 irq after clear", irq, 0);
        wr(1'b1, 8'h40);

        // R2 / R3 / R9 period sweep over every running rate
        for (int k = 1; k < 8; k++) begin
            for (int j = 0; j < 5; j++) begin
                int d;
                int per;
                d = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 2 : (j == 3) ? 5 : 13;
                per = (d + 1) * (1 << (k - 1));
                if (per >= 2) begin
                    wr(1'b0, 8'(d));
                    wr(1'b1, 8'hC8);
                    wr(1'b1, 8'(8'h80 | k));
                    wait_irq(c);
                    wr(1'b1, 8'(8'hC0 | k));
                    wait_irq(c);
                    check($sformatf("R2 R3 R9 period sel=%0d mod=%0d", k, d), c + 1, per);
                    wr(1'b1, 8'(8'hC0 | k));
                    wait_irq(c);
                    check($sformatf("R2 R9 repeat sel=%0d mod=%0d", k, d), c + 1, per);
                    wr(1'b1, 8'h40);
                end
            end
        end

        // R2 full-range modulus
        wr(1'b0, 8'd255);
        wr(1'b1, 8'hC8);
        wr(1'b1, 8'h82);
        wait_irq(c);
        wr(1'b1, 8'hC2);
        wait_irq(c);
        check("R2 period mod=255 sel=2", c + 1, 512);
        wr(1'b1, 8'h40);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule